// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds stores that have been decoded but not yet retired, in a circular queue of slots ordered by program order. The front end claims a slot at decode and learns its index from the tail pointer. The address half and the data half of each store reach the slot as two separate operations, and they may arrive in either order. Each slot keeps a valid flag, a speculative flag and a presence flag for each half.

A commit pointer walks the queue from oldest to youngest. When retirement logic signals that the store at the commit pointer is the oldest instruction, the store retires only if both halves are present. Retiring clears its speculative flag. Retired slots then leave the queue from the head, one per cycle, through a simple cache-write handshake, and each departure frees its slot. A flush takes a new tail value and drops every speculative slot at or beyond that point in one cycle.

Loads present an address and an age, which is the tail value captured when the load was decoded. The buffer looks at the stores older than that age. If the youngest older store with a matching address has its data, the buffer returns a hit with that data, and this data takes precedence over the cache. If an older store has no address yet, or the matching store has no data yet, the buffer reports unknown and the load must retry. Otherwise the load reads the cache.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ok` is 1, `tail_ptr` is 0, `wr_vld` is 0, and a load at any address reports neither hit nor unknown.
- R2: Each accepted allocation takes slot `tail_ptr[2:0]` and advances `tail_ptr` by one; `tail_ptr` carries one wrap bit above the slot index. With 8 slots occupied `alloc_ok` is 0 and an allocation request leaves `tail_ptr` unchanged.
- R3: The address and data halves can be written in either order. `commit_ok` is 1 in the cycle where `commit_req` is high only if the slot at the commit pointer is valid, speculative and holds both halves; otherwise no commit takes place.
- R4: `wr_vld` is high exactly while retired slots remain. The port presents the oldest retired slot's address and data, holds them stable until `wr_rdy`, and advances by one slot per accepted write. Speculative slots never reach the port.
- R5: A load with `ld_vld` reports `ld_hit` with the data of the youngest matching store among slots older than `ld_age`.
- R6: Stores at or after `ld_age` in program order do not affect a load's result.
- R7: `ld_unknown` is 1, and `ld_hit` is 0, when an older slot lacks its address or when the selected matching slot lacks its data.
- R8: When no older slot matches and no older address is missing, both `ld_hit` and `ld_unknown` are 0, and the load falls through to the cache.
- R9: A flush sets `tail_ptr` to `flush_tail` and invalidates the speculative slots from that point onward. The freed slots can be allocated again and start with no address and no data.
- R10: Retired slots that have not yet been written to the cache still forward to loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Claim a slot at decode |
| alloc_ok | output | 1 | A slot is free |
| tail_ptr | output | 4 | Next slot to allocate, with wrap bit |
| saddr_vld | input | 1 | Store-address operation |
| saddr_idx | input | 3 | Slot of the address operation |
| saddr_val | input | 32 | Store address |
| sdata_vld | input | 1 | Store-data operation |
| sdata_idx | input | 3 | Slot of the data operation |
| sdata_val | input | 32 | Store data |
| commit_req | input | 1 | Store at the commit pointer is oldest in flight |
| commit_ok | output | 1 | The commit takes place this cycle |
| flush_vld | input | 1 | Discard younger speculative stores |
| flush_tail | input | 4 | Tail value to restore |
| ld_vld | input | 1 | Load lookup |
| ld_addr | input | 32 | Load address |
| ld_age | input | 4 | Tail value captured at the load's decode |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_unknown | output | 1 | Load must retry |
| ld_data | output | 32 | Forwarded data |
| wr_vld | output | 1 | Cache write request |
| wr_rdy | input | 1 | Cache accepts the write |
| wr_addr | output | 32 | Cache write address |
| wr_data | output | 32 | Cache write data |

## Verification
A wrong presence flag or pointer shows up in the same cycle on the combinational load outputs. It appears as a hit in place of unknown, or as data taken from an older or younger slot than the right one. The stimulus therefore sweeps the load age across a set of stores that share one address. A commit pointer or speculative flag that goes astray appears one cycle later at the cache-write port, as a write that comes early, in the wrong order or never. A flush that clears the wrong range appears when the freed slots are allocated again: it changes how many allocations succeed before `alloc_ok` falls, and whether a stale address still answers a load.

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic          alloc_ok,
  output logic [PW-1:0] tail_ptr,
  input  logic          saddr_vld,
  input  logic [IW-1:0] saddr_idx,
  input  logic [AW-1:0] saddr_val,
  input  logic          sdata_vld,
  input  logic [IW-1:0] sdata_idx,
  input  logic [DW-1:0] sdata_val,
  input  logic          commit_req,
  output logic          commit_ok,
  input  logic          flush_vld,
  input  logic [PW-1:0] flush_tail,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_addr,
  input  logic [PW-1:0] ld_age,
  output logic          ld_hit,
  output logic          ld_unknown,
  output logic [DW-1:0] ld_data,
  output logic          wr_vld,
  input  logic          wr_rdy,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic [PW-1:0]    head, tail, cptr, count, fl_off, off_raw, ld_off;
  logic [DEPTH-1:0] v, spec, has_a, has_d, kill;
  logic [DEPTH-1:0] alloc_m, drain_m, commit_m, a_set, d_set;
  logic [AW-1:0]    tag [DEPTH];
  logic [DW-1:0]    dat [DEPTH];
  logic [IW-1:0]    hidx, tidx, cidx, sel, idx;
  logic             alloc_fire, found, unk;

  assign hidx     = head[IW-1:0];
  assign tidx     = tail[IW-1:0];
  assign cidx     = cptr[IW-1:0];
  assign count    = tail - head;
  assign alloc_ok = count != PW'(DEPTH);
  assign tail_ptr = tail;

  assign alloc_fire = alloc_req && alloc_ok && !flush_vld;
  assign commit_ok  = commit_req && (cptr != tail) && v[cidx] && spec[cidx]
                      && has_a[cidx] && has_d[cidx];
  assign wr_vld   = head != cptr;
  assign wr_addr  = tag[hidx];
  assign wr_data  = dat[hidx];

  assign alloc_m  = alloc_fire ? (DEPTH'(1) << tidx) : '0;
  assign drain_m  = (wr_vld && wr_rdy) ? (DEPTH'(1) << hidx) : '0;
  assign commit_m = commit_ok ? (DEPTH'(1) << cidx) : '0;
  assign a_set    = saddr_vld ? ((DEPTH'(1) << saddr_idx) & v) : '0;
  assign d_set    = sdata_vld ? ((DEPTH'(1) << sdata_idx) & v) : '0;

  assign fl_off = flush_tail - head;
  always_comb
    for (int i = 0; i < DEPTH; i++)
      kill[i] = flush_vld && v[i] && spec[i]
                && ({1'b0, IW'(i) - hidx} >= fl_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cptr  <= '0;
      v     <= '0;
      spec  <= '0;
      has_a <= '0;
      has_d <= '0;
    end else begin
      v     <= (v & ~kill & ~drain_m) | alloc_m;
      spec  <= (spec & ~commit_m) | alloc_m;
      has_a <= (has_a | a_set) & ~alloc_m;
      has_d <= (has_d | d_set) & ~alloc_m;
      if (commit_ok) cptr <= cptr + 1'b1;
      if (wr_vld && wr_rdy) head <= head + 1'b1;
      if (flush_vld) tail <= flush_tail;
      else if (alloc_fire) tail <= tail + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (saddr_vld && v[saddr_idx]) tag[saddr_idx] <= saddr_val;
    if (sdata_vld && v[sdata_idx]) dat[sdata_idx] <= sdata_val;
  end

  assign off_raw = ld_age - head;
  assign ld_off  = (off_raw > count) ? '0 : off_raw;

  always_comb begin
    found = 1'b0;
    unk   = 1'b0;
    sel   = '0;
    idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = hidx + IW'(k);
      if (PW'(k) < ld_off && v[idx]) begin
        if (!has_a[idx]) unk = 1'b1;
        else if (tag[idx] == ld_addr) begin
          found = 1'b1;
          sel   = idx;
        end
      end
    end
  end

  assign ld_unknown = ld_vld && (unk || (found && !has_d[sel]));
  assign ld_hit     = ld_vld && found && !ld_unknown;
  assign ld_data    = dat[sel];

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_ok && !flush_vld) |=> $stable(tail_ptr));

  a_r7_hit_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_unknown));

  a_r4_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !wr_rdy) |=> (wr_vld && $stable(wr_addr) && $stable(wr_data)));

  a_r4_drain_retired: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> (v[hidx] && !spec[hidx] && has_a[hidx] && has_d[hidx]));

endmodule

// File: tb/test_spec_store_buf.sv
module test_spec_store_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0, alloc_ok;
  logic [3:0]  tail_ptr;
  logic        saddr_vld = 1'b0, sdata_vld = 1'b0;
  logic [2:0]  saddr_idx = '0, sdata_idx = '0;
  logic [31:0] saddr_val = '0, sdata_val = '0;
  logic        commit_req = 1'b0, commit_ok;
  logic        flush_vld = 1'b0;
  logic [3:0]  flush_tail = '0;
  logic        ld_vld = 1'b0, ld_hit, ld_unknown;
  logic [31:0] ld_addr = '0, ld_data;
  logic [3:0]  ld_age = '0;
  logic        wr_vld, wr_rdy = 1'b0;
  logic [31:0] wr_addr, wr_data;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  spec_store_buf i_spec_store_buf (.*);

  // {addr, age, hit, unknown, data}; slots 0..3 hold 100/A0, 200/B1, 100/C2, 300/--; slot 4 has no address
  localparam logic [69:0] LDV [0:8] = '{
    {32'h100, 4'd4, 1'b1, 1'b0, 32'hC2},
    {32'h100, 4'd2, 1'b1, 1'b0, 32'hA0},
    {32'h100, 4'd1, 1'b1, 1'b0, 32'hA0},
    {32'h100, 4'd0, 1'b0, 1'b0, 32'h0},
    {32'h300, 4'd4, 1'b0, 1'b1, 32'h0},
    {32'h400, 4'd4, 1'b0, 1'b0, 32'h0},
    {32'h200, 4'd4, 1'b1, 1'b0, 32'hB1},
    {32'h400, 4'd5, 1'b0, 1'b1, 32'h0},
    {32'h200, 4'd3, 1'b1, 1'b0, 32'hB1}
  };
  string ldtag [0:8] = '{"R5", "R6", "R6", "R8", "R7", "R8", "R5", "R7", "R5"};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic alloc();
    alloc_req = 1'b1; tick(); alloc_req = 1'b0;
  endtask

  task automatic w_addr(input logic [2:0] i, input logic [31:0] a);
    saddr_vld = 1'b1; saddr_idx = i; saddr_val = a; tick(); saddr_vld = 1'b0;
  endtask

  task automatic w_data(input logic [2:0] i, input logic [31:0] d);
    sdata_vld = 1'b1; sdata_idx = i; sdata_val = d; tick(); sdata_vld = 1'b0;
  endtask

  task automatic load(string req, input logic [31:0] a, input logic [3:0] age,
                      input logic eh, input logic eu, input logic [31:0] ed);
    ld_vld = 1'b1; ld_addr = a; ld_age = age;
    #1;
    chk(req, {31'b0, ld_hit}, {31'b0, eh});
    chk(req, {31'b0, ld_unknown}, {31'b0, eu});
    if (eh) chk(req, ld_data, ed);
    ld_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 alloc_ok", {31'b0, alloc_ok}, 32'd1);
    chk("R1 tail", {28'b0, tail_ptr}, 32'd0);
    chk("R1 wr_vld", {31'b0, wr_vld}, 32'd0);
    load("R1", 32'h100, 4'd0, 1'b0, 1'b0, 32'h0);
    tick();

    for (int s = 0; s < 5; s++) alloc();
    w_data(3'd0, 32'hA0);
    w_addr(3'd0, 32'h100);
    saddr_vld = 1'b1; saddr_idx = 3'd1; saddr_val = 32'h200;
    sdata_vld = 1'b1; sdata_idx = 3'd1; sdata_val = 32'hB1;
    tick(); saddr_vld = 1'b0; sdata_vld = 1'b0;
    w_addr(3'd2, 32'h100);
    w_data(3'd2, 32'hC2);
    w_addr(3'd3, 32'h300);
    #1;
    chk("R2 tail after 5", {28'b0, tail_ptr}, 32'd5);
    chk("R4 no drain of speculative", {31'b0, wr_vld}, 32'd0);

    for (int n = 0; n < 9; n++)
      load(ldtag[n], LDV[n][69:38], LDV[n][37:34], LDV[n][33], LDV[n][32], LDV[n][31:0]);
    tick();

    for (int c = 0; c < 3; c++) begin
      commit_req = 1'b1; #1;
      chk("R3 commit ok", {31'b0, commit_ok}, 32'd1);
      tick(); commit_req = 1'b0;
    end
    commit_req = 1'b1; #1;
    chk("R3 commit needs data", {31'b0, commit_ok}, 32'd0);
    tick(); commit_req = 1'b0;
    #1;
    chk("R4 wr_vld", {31'b0, wr_vld}, 32'd1);
    chk("R4 wr_addr", wr_addr, 32'h100);
    chk("R4 wr_data", wr_data, 32'hA0);
    load("R10 retired forwards", 32'h200, 4'd2, 1'b1, 1'b0, 32'hB1);
    load("R10 younger wins", 32'h100, 4'd4, 1'b1, 1'b0, 32'hC2);
    tick();
    w_data(3'd3, 32'hD3);
    load("R3 addr then data", 32'h300, 4'd4, 1'b1, 1'b0, 32'hD3);
    tick();

    flush_vld = 1'b1; flush_tail = 4'd3; tick(); flush_vld = 1'b0;
    #1;
    chk("R9 tail", {28'b0, tail_ptr}, 32'd3);
    chk("R9 alloc_ok", {31'b0, alloc_ok}, 32'd1);
    tick();
    for (int s = 0; s < 5; s++) alloc();
    #1;
    chk("R2 tail full", {28'b0, tail_ptr}, 32'd8);
    chk("R2 full", {31'b0, alloc_ok}, 32'd0);
    load("R9 stale addr gone", 32'h300, 4'd4, 1'b0, 1'b1, 32'h0);
    alloc();
    #1;
    chk("R2 alloc ignored", {28'b0, tail_ptr}, 32'd8);
    chk("R4 held", wr_data, 32'hA0);

    wr_rdy = 1'b1; #1;
    chk("R4 first", wr_data, 32'hA0);
    tick(); #1;
    chk("R4 second addr", wr_addr, 32'h200);
    chk("R4 second", wr_data, 32'hB1);
    tick(); #1;
    chk("R4 third", wr_data, 32'hC2);
    tick(); #1;
    chk("R4 drained", {31'b0, wr_vld}, 32'd0);
    chk("R4 slots freed", {31'b0, alloc_ok}, 32'd1);
    wr_rdy = 1'b0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule